// File: doc/BRIEF.md
# Slot-timed radio sequencer

This block steps a cordless radio front end through its slot timeline: idle, a blind slot in which the synthesizer locks, an active slot in which the radio transmits or receives, and back to power-down. It watches the enable and clock lines of the serial configuration port, an optional power-down pin and the threshold-control input. From these it drives synthesizer enable, loop-closed, VCO power, receiver power, transmit preamplifier enable and the two antenna-switch outputs. Analog settling is not modelled. The surrounding system supplies all timing as edges on these inputs.

Four option bits are sampled at the moment a programming burst is committed: receive/transmit select, preamplifier gating, antenna-follow and loop-hold. They shape what the active slot does. The parameter `PD_STYLE` picks how power-down is requested:
- 0: a stop pulse on enable.
- 1: a falling edge on a dedicated pin.
- 2: a level mode, in which the chip stays awake while clock or enable is high.

Two pulse outputs report whether an edge was taken as a commit or as a power-down.

All inputs pass through a `SYNC_STAGES`-deep synchronizer before they are used.

Top module: `slot_seq`

## Requirements
- R1: After reset every output is low, including `commit_flag` and `stop_flag`.
- R2: In styles 0 and 1, an enable rising edge counts as a commit if at least one serial-clock rising edge occurred while enable was low. A commit enters the blind slot, with `synth_en`, `loop_closed` and `vco_pwr` high and `rx_pwr`, `tx_ant` and `rx_ant` low, and pulses `commit_flag`.
- R3: In the blind slot, `tx_pa_en` is high only when transmit is selected (`cfg_rx`=0) and preamplifier gating (`cfg_pa_gate`) is 0.
- R4: An enable falling edge in the blind slot moves to the active slot with `vco_pwr` high. `synth_en` and `loop_closed` go low unless `cfg_loop_hold`=1, or transmit is selected with `cfg_pa_gate`=1.
- R5: In a receive active slot, `rx_pwr` and `rx_ant` are high and `tx_pa_en` and `tx_ant` are low. `rx_pwr` does not change within the slot.
- R6: In a transmit active slot with `cfg_pa_gate`=0 and `cfg_ant_follow`=0, `tx_pa_en` and `tx_ant` stay high whatever `thr_ctl` does.
- R7: In a transmit active slot with `cfg_pa_gate`=1, `tx_pa_en` and `tx_ant` both follow `thr_ctl`, and the loop stays closed.
- R8: In a transmit active slot with `cfg_ant_follow`=1 and `cfg_pa_gate`=0, `tx_ant` follows `thr_ctl` while `tx_pa_en` stays high.
- R9: In style 0, an enable rising edge with no serial-clock rising edge in the preceding low phase is a stop: the sequencer goes idle and `stop_flag` pulses. With a clock edge, the same rising edge recommits instead. The power-down pin has no effect in this style.
- R10: In style 1, a falling edge on `pd_n` powers down, its rising edge has no effect, and a stop pulse on enable leaves the active slot running.
- R11: In style 2, a commit is an enable falling edge after at least one serial-clock falling edge while enable was high. The next enable falling edge enters the active slot. The sequencer stays awake while clock or enable is high, and goes idle once both are low.
- R12: A power-down request taken from the blind or active slot sends the sequencer to idle, with all outputs low, on the next clock edge.
- R13: The option bits are captured at commit. Later changes on the `cfg_*` inputs have no effect until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Configuration port enable line |
| bus_clk | input | 1 | Configuration port serial clock |
| pd_n | input | 1 | Power-down pin; a falling edge powers down in style 1 |
| thr_ctl | input | 1 | Threshold-control input used for gating in transmit |
| cfg_rx | input | 1 | 1 selects receive, 0 selects transmit |
| cfg_pa_gate | input | 1 | Gate the preamplifier and antenna with `thr_ctl` in transmit |
| cfg_ant_follow | input | 1 | Transmit antenna drive follows `thr_ctl` |
| cfg_loop_hold | input | 1 | Keep the loop closed in the active slot |
| synth_en | output | 1 | Synthesizer enable |
| loop_closed | output | 1 | Phase-locked loop closed |
| vco_pwr | output | 1 | VCO power |
| rx_pwr | output | 1 | Receiver power |
| tx_pa_en | output | 1 | Transmit preamplifier enable |
| tx_ant | output | 1 | Transmit antenna-switch drive |
| rx_ant | output | 1 | Receive antenna-switch drive |
| commit_flag | output | 1 | One-cycle pulse on a commit |
| stop_flag | output | 1 | One-cycle pulse when a power-down is taken |

## Verification
The bench targets the single edge that can mean two things: an enable rising edge with or without clock activity in the low phase just before it. A design that mixes these up would either drop a live slot when reprogrammed, or keep radiating after a stop pulse. It also checks the style-1 instance against the same stop pulse, which must be ignored, and checks that a pin rising edge does not wake anything.

In transmit, the three option combinations for `thr_ctl` gating are exercised. A wrong decode would show up as a preamplifier left on through the whole slot, or as an antenna switch that ignores the threshold input. A run that changes the `cfg_*` inputs mid-slot catches a design that reads them live instead of latching them at commit.

In the clock-level style, a mid-word clock low while enable is high must not power the chip down, and an enable burst with no clock edges must not commit.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_BLIND  = 2'd1,
      ST_ACTIVE = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic rx;
      logic pa_gate;
      logic ant_follow;
      logic loop_hold;
   } slot_cfg_t;

   localparam int PD_STOP_PULSE = 0;
   localparam int PD_PIN        = 1;
   localparam int PD_CLK_LEVEL  = 2;

endpackage

// File: rtl/slot_seq_sync.sv
module slot_seq_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] chg
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("slot_seq_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic [STAGES-1:0] pipe;
         logic              last;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe <= '0;
               else        pipe <= din[i];
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe <= '0;
               else        pipe <= {pipe[STAGES-2:0], din[i]};
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) last <= 1'b0;
            else        last <= pipe[STAGES-1];
         end
         assign lvl[i] = pipe[STAGES-1];
         assign chg[i] = pipe[STAGES-1] ^ last;
      end
   endgenerate

endmodule

// File: rtl/slot_seq_classify.sv
module slot_seq_classify #(
   parameter int VARIANT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_lvl,
   input  logic en_chg,
   input  logic sclk_lvl,
   input  logic sclk_chg,
   input  logic pd_lvl,
   input  logic pd_chg,
   output logic commit_ev,
   output logic adv_ev,
   output logic pd_req
);

   localparam bit LEVEL_MODE = (VARIANT == 2);

   generate
      if (VARIANT < 0 || VARIANT > 2) begin : g_bad_variant
         $error("slot_seq_classify: VARIANT must be 0, 1 or 2");
      end
   endgenerate

   logic en_rise, en_fall, sclk_edge, window, win_open, win_close;
   logic seen;

   assign en_rise   = en_chg & en_lvl;
   assign en_fall   = en_chg & ~en_lvl;
   // active serial-clock edge: falling in level mode, rising otherwise
   assign sclk_edge = sclk_chg & (LEVEL_MODE ? ~sclk_lvl : sclk_lvl);
   // programming window: enable high in level mode, enable low otherwise
   assign window    = LEVEL_MODE ? en_lvl : ~en_lvl;
   assign win_open  = LEVEL_MODE ? en_rise : en_fall;
   assign win_close = LEVEL_MODE ? en_fall : en_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen <= 1'b0;
      else if (win_open)             seen <= sclk_edge & window;
      else if (sclk_edge && window)  seen <= 1'b1;
   end

   assign commit_ev = win_close & seen;
   assign adv_ev    = en_fall;
   assign pd_req    = (VARIANT == 0) ? (en_rise & ~seen) :
                      (VARIANT == 1) ? (pd_chg & ~pd_lvl) :
                                       (~sclk_lvl & ~en_lvl);

endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
   import slot_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       commit_ev,
   input  logic       adv_ev,
   input  logic       pd_req,
   input  slot_cfg_t  cfg_in,
   output seq_state_t state,
   output slot_cfg_t  cfg_q,
   output logic       commit_flag,
   output logic       stop_flag
);

   logic pd_take, adv_take;

   assign pd_take  = pd_req && (state != ST_IDLE);
   assign adv_take = (state == ST_BLIND) && adv_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cfg_q       <= '0;
         commit_flag <= 1'b0;
         stop_flag   <= 1'b0;
      end else begin
         commit_flag <= 1'b0;
         stop_flag   <= 1'b0;
         if (pd_take) begin
            state     <= ST_IDLE;
            stop_flag <= 1'b1;
         end else if (adv_take) begin
            state <= ST_ACTIVE;
         end else if (commit_ev) begin
            state       <= ST_BLIND;
            cfg_q       <= cfg_in;
            commit_flag <= 1'b1;
         end
      end
   end

   // R12
   pwrdn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_req && state != ST_IDLE) |=> (state == ST_IDLE && stop_flag));

   // R2
   commit_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_ev && !pd_take && !adv_take) |=> (state == ST_BLIND && commit_flag));

   // R4
   active_from_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> $past(state) == ST_BLIND);

endmodule

// File: rtl/slot_seq_outdec.sv
module slot_seq_outdec
   import slot_seq_pkg::*;
#(
   parameter int THR_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_t state,
   input  slot_cfg_t  cfg_q,
   input  logic       thr_ctl,
   output logic       synth_en,
   output logic       loop_closed,
   output logic       vco_pwr,
   output logic       rx_pwr,
   output logic       tx_pa_en,
   output logic       tx_ant,
   output logic       rx_ant
);

   logic [THR_STAGES-1:0] thr_pipe;
   logic                  thr_s, is_tx, hold;

   generate
      if (THR_STAGES == 1) begin : g_thr_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) thr_pipe <= '0;
            else        thr_pipe <= thr_ctl;
         end
      end else begin : g_thr_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) thr_pipe <= '0;
            else        thr_pipe <= {thr_pipe[THR_STAGES-2:0], thr_ctl};
         end
      end
   endgenerate

   assign thr_s = thr_pipe[THR_STAGES-1];
   assign is_tx = ~cfg_q.rx;
   assign hold  = cfg_q.loop_hold | (is_tx & cfg_q.pa_gate);

   always_comb begin
      synth_en    = 1'b0;
      loop_closed = 1'b0;
      vco_pwr     = 1'b0;
      rx_pwr      = 1'b0;
      tx_pa_en    = 1'b0;
      tx_ant      = 1'b0;
      unique case (state)
         ST_BLIND: begin
            synth_en    = 1'b1;
            loop_closed = 1'b1;
            vco_pwr     = 1'b1;
            tx_pa_en    = is_tx & ~cfg_q.pa_gate;
         end
         ST_ACTIVE: begin
            synth_en    = hold;
            loop_closed = hold;
            vco_pwr     = 1'b1;
            rx_pwr      = cfg_q.rx;
            tx_pa_en    = is_tx & (cfg_q.pa_gate ? thr_s : 1'b1);
            tx_ant      = is_tx & ((cfg_q.pa_gate | cfg_q.ant_follow) ? thr_s : 1'b1);
         end
         default: ;
      endcase
   end

   assign rx_ant = rx_pwr;

   // R5
   rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && $past(state) == ST_ACTIVE) |-> $stable(rx_pwr));

endmodule

// File: rtl/slot_seq.sv
module slot_seq
   import slot_seq_pkg::*;
#(
   parameter int PD_STYLE    = PD_STOP_PULSE,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_en,
   input  logic bus_clk,
   input  logic pd_n,
   input  logic thr_ctl,
   input  logic cfg_rx,
   input  logic cfg_pa_gate,
   input  logic cfg_ant_follow,
   input  logic cfg_loop_hold,
   output logic synth_en,
   output logic loop_closed,
   output logic vco_pwr,
   output logic rx_pwr,
   output logic tx_pa_en,
   output logic tx_ant,
   output logic rx_ant,
   output logic commit_flag,
   output logic stop_flag
);

   localparam int N_SYNC = 3;
   localparam int IDX_EN = 0;
   localparam int IDX_CK = 1;
   localparam int IDX_PD = 2;

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("slot_seq: SYNC_STAGES must lie in 1..4");
      end
      if (PD_STYLE < PD_STOP_PULSE || PD_STYLE > PD_CLK_LEVEL) begin : g_bad_style
         $error("slot_seq: unknown PD_STYLE");
      end
   endgenerate

   logic [N_SYNC-1:0] s_lvl, s_chg;
   logic              commit_ev, adv_ev, pd_req;
   seq_state_t        state;
   slot_cfg_t         cfg_in, cfg_q;

   assign cfg_in = '{rx: cfg_rx, pa_gate: cfg_pa_gate,
                     ant_follow: cfg_ant_follow, loop_hold: cfg_loop_hold};

   slot_seq_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({pd_n, bus_clk, bus_en}),
      .lvl   (s_lvl),
      .chg   (s_chg)
   );

   slot_seq_classify #(.VARIANT(PD_STYLE)) u_cls (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_lvl    (s_lvl[IDX_EN]),
      .en_chg    (s_chg[IDX_EN]),
      .sclk_lvl  (s_lvl[IDX_CK]),
      .sclk_chg  (s_chg[IDX_CK]),
      .pd_lvl    (s_lvl[IDX_PD]),
      .pd_chg    (s_chg[IDX_PD]),
      .commit_ev (commit_ev),
      .adv_ev    (adv_ev),
      .pd_req    (pd_req)
   );

   slot_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_ev   (commit_ev),
      .adv_ev      (adv_ev),
      .pd_req      (pd_req),
      .cfg_in      (cfg_in),
      .state       (state),
      .cfg_q       (cfg_q),
      .commit_flag (commit_flag),
      .stop_flag   (stop_flag)
   );

   slot_seq_outdec #(.THR_STAGES(SYNC_STAGES)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .cfg_q       (cfg_q),
      .thr_ctl     (thr_ctl),
      .synth_en    (synth_en),
      .loop_closed (loop_closed),
      .vco_pwr     (vco_pwr),
      .rx_pwr      (rx_pwr),
      .tx_pa_en    (tx_pa_en),
      .tx_ant      (tx_ant),
      .rx_ant      (rx_ant)
   );

endmodule

// File: tb/slot_seq_tb.sv
module slot_seq_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, sclk = 1'b0, pdp = 1'b1, thr = 1'b0;
   logic en2 = 1'b0, sclk2 = 1'b0;
   logic c_rx = 1'b0, c_pg = 1'b0, c_af = 1'b0, c_lh = 1'b0;

   // output vectors, bit order: synth, loop, vco, rx_pwr, pa, tx_ant, rx_ant
   logic [6:0] oa, ob, oc;
   logic a_commit, a_stop, b_commit, b_stop, c_commit, c_stop;

   int n_chk = 0, n_fail = 0, n_cmt = 0, n_stp = 0;

   always #4 clk = ~clk;

   slot_seq #(.PD_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_clk(sclk), .pd_n(pdp), .thr_ctl(thr),
      .cfg_rx(c_rx), .cfg_pa_gate(c_pg), .cfg_ant_follow(c_af), .cfg_loop_hold(c_lh),
      .synth_en(oa[6]), .loop_closed(oa[5]), .vco_pwr(oa[4]), .rx_pwr(oa[3]),
      .tx_pa_en(oa[2]), .tx_ant(oa[1]), .rx_ant(oa[0]),
      .commit_flag(a_commit), .stop_flag(a_stop));

   slot_seq #(.PD_STYLE(1)) u_dut_pin (
      .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_clk(sclk), .pd_n(pdp), .thr_ctl(thr),
      .cfg_rx(c_rx), .cfg_pa_gate(c_pg), .cfg_ant_follow(c_af), .cfg_loop_hold(c_lh),
      .synth_en(ob[6]), .loop_closed(ob[5]), .vco_pwr(ob[4]), .rx_pwr(ob[3]),
      .tx_pa_en(ob[2]), .tx_ant(ob[1]), .rx_ant(ob[0]),
      .commit_flag(b_commit), .stop_flag(b_stop));

   slot_seq #(.PD_STYLE(2)) u_dut_lvl (
      .clk(clk), .rst_n(rst_n), .bus_en(en2), .bus_clk(sclk2), .pd_n(1'b1), .thr_ctl(thr),
      .cfg_rx(c_rx), .cfg_pa_gate(c_pg), .cfg_ant_follow(c_af), .cfg_loop_hold(c_lh),
      .synth_en(oc[6]), .loop_closed(oc[5]), .vco_pwr(oc[4]), .rx_pwr(oc[3]),
      .tx_pa_en(oc[2]), .tx_ant(oc[1]), .rx_ant(oc[0]),
      .commit_flag(c_commit), .stop_flag(c_stop));

   always @(posedge clk) begin
      if (rst_n && a_commit) n_cmt++;
      if (rst_n && a_stop)   n_stp++;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic chk_n(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // clock pulses while enable low, then enable rise
   task automatic prog(input int pulses);
      for (int i = 0; i < pulses; i++) begin
         sclk = 1'b1; step(3);
         sclk = 1'b0; step(3);
      end
      en = 1'b1; step(6);
   endtask

   task automatic idle_all;
      en = 1'b1; step(6);
      en = 1'b0; step(6);
      pdp = 1'b0; step(6);
      pdp = 1'b1; step(6);
      chk("R12 idle_all style0", oa, 7'b0);
      chk("R12 idle_all style1", ob, 7'b0);
   endtask

   task automatic t_reset;
      chk("R1 reset style0", oa, 7'b0);
      chk("R1 reset style1", ob, 7'b0);
      chk("R1 reset style2", oc, 7'b0);
      chk_n("R1 flags low", int'({a_commit, a_stop, c_commit, c_stop}), 0);
   endtask

   task automatic t_rx_cycle;
      int c0, s0;
      c_rx = 1'b1; c_pg = 1'b0; c_af = 1'b0; c_lh = 1'b0;
      c0 = n_cmt; s0 = n_stp;
      prog(3);
      chk("R2 blind rx style0", oa, 7'b1110000);
      chk("R2 blind rx style1", ob, 7'b1110000);
      chk_n("R2 commit_flag count", n_cmt - c0, 1);
      en = 1'b0; step(6);
      chk("R4 R5 active rx style0", oa, 7'b0011001);
      chk("R5 active rx style1", ob, 7'b0011001);
      en = 1'b1; step(6);
      chk("R9 stop pulse idles", oa, 7'b0);
      chk_n("R9 stop_flag count", n_stp - s0, 1);
      chk("R10 stop pulse ignored style1", ob, 7'b0011001);
      en = 1'b0; step(6);
      pdp = 1'b0; step(6);
      chk("R10 pin fall powers down", ob, 7'b0);
      pdp = 1'b1; step(6);
      chk("R10 pin rise ignored", ob, 7'b0);
   endtask

   task automatic t_tx_reprog;
      int c0;
      c_rx = 1'b0;
      prog(2);
      chk("R3 blind tx preamp on", oa, 7'b1110100);
      en = 1'b0; step(6);
      chk("R6 active tx default", oa, 7'b0010110);
      thr = 1'b1; step(6);
      chk("R6 thr_ctl ignored", oa, 7'b0010110);
      thr = 1'b0; step(6);
      chk("R6 thr_ctl low ignored", oa, 7'b0010110);
      c_rx = 1'b1; c0 = n_cmt;
      prog(1);
      chk("R9 reprogram enters blind", oa, 7'b1110000);
      chk_n("R9 reprogram commit count", n_cmt - c0, 1);
      en = 1'b0; step(6);
      chk("R5 active rx after reprogram", oa, 7'b0011001);
      idle_all();
   endtask

   task automatic t_gate;
      c_rx = 1'b0; c_pg = 1'b1; c_af = 1'b0; c_lh = 1'b0;
      prog(1);
      chk("R3 blind preamp gated off", oa, 7'b1110000);
      en = 1'b0; step(6);
      chk("R7 gate low loop held", oa, 7'b1110000);
      thr = 1'b1; step(6);
      chk("R7 gate high", oa, 7'b1110110);
      c_rx = 1'b1; c_pg = 1'b0; step(6);
      chk("R13 cfg change ignored", oa, 7'b1110110);
      thr = 1'b0; step(6);
      chk("R7 gate low again", oa, 7'b1110000);
      idle_all();
      c_pg = 1'b0;
   endtask

   task automatic t_ant;
      c_rx = 1'b0; c_pg = 1'b0; c_af = 1'b1; c_lh = 1'b1;
      prog(1);
      chk("R3 blind ant-follow", oa, 7'b1110100);
      en = 1'b0; step(6);
      chk("R8 R4 ant low loop held", oa, 7'b1110100);
      thr = 1'b1; step(6);
      chk("R8 ant follows thr", oa, 7'b1110110);
      thr = 1'b0; step(6);
      idle_all();
      c_af = 1'b0; c_lh = 1'b0;
   endtask

   task automatic t_pd_blind;
      c_rx = 1'b1;
      prog(1);
      pdp = 1'b0; step(6);
      chk("R12 pin power-down from blind", ob, 7'b0);
      chk("R9 pin no effect style0", oa, 7'b1110000);
      pdp = 1'b1;
      en = 1'b0; step(6);
      chk("R5 style0 active", oa, 7'b0011001);
      en = 1'b1; step(6);
      chk("R12 stop from active", oa, 7'b0);
      en = 1'b0; step(6);
   endtask

   task automatic t_level;
      c_rx = 1'b0; c_pg = 1'b0; c_af = 1'b0; c_lh = 1'b0;
      sclk2 = 1'b1; step(6);
      chk("R11 clock high alone no commit", oc, 7'b0);
      en2 = 1'b1; step(6);
      for (int i = 0; i < 2; i++) begin
         sclk2 = 1'b0; step(3);
         sclk2 = 1'b1; step(3);
      end
      en2 = 1'b0; step(6);
      chk("R11 commit on enable fall", oc, 7'b1110100);
      en2 = 1'b1; step(6);
      sclk2 = 1'b0; step(6);
      chk("R11 awake while enable high", oc, 7'b1110100);
      sclk2 = 1'b1; step(3);
      en2 = 1'b0; step(6);
      chk("R11 active after short word", oc, 7'b0010110);
      sclk2 = 1'b0; step(6);
      chk("R11 both low powers down", oc, 7'b0);
      sclk2 = 1'b1; step(6);
      en2 = 1'b1; step(6);
      en2 = 1'b0; step(6);
      chk("R11 enable burst without clocks", oc, 7'b0);
      sclk2 = 1'b0; step(6);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(5);
      rst_n = 1'b1;
      step(6);
      t_reset();
      t_rx_cycle();
      t_tx_reprog();
      t_gate();
      t_ant();
      t_pd_blind();
      t_level();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule